// File: doc/BRIEF.md
# Message Object Transfer Controller

This block moves field groups between one entry of a small message-object RAM and a local interface buffer. Each entry is one CAN-style message object. Its groups are the control word, the arbitration word, the mask word and two 32-bit data halves. Software loads a command mask that picks the groups and the direction. It then writes an object number to the request port, which starts the transfer and raises `busy` until the RAM work is done.

In the read direction, the selected groups are copied from the object into the buffer. The same operation can also clear the object's new-data and interrupt-pending flags in RAM. The buffer always receives the flag values from before the clear. In the write direction, the selected groups are merged from the buffer into the object through a read-modify-write of the RAM entry. Every transfer first reads the entry and then optionally writes it back, with no variable latency.

Top module: `msgobj_xfer`

## Requirements
- R1: After reset, `busy`, `ram_rd_en`, `ram_wr_en`, `buf_q` and `mask_rdata` are all zero.
- R2: A mask write stores bits 7:0 of `mask_wdata`. `mask_rdata` returns those bits and reads zero in bits 31:8.
- R3: A request only starts a transfer if the object number is in the range 1 to NUM_OBJ. A request with number 0 or above NUM_OBJ leaves `busy` low and causes no RAM access.
- R4: A read (mask bit 7 clear) with mask bits 2 and 3 both clear holds `busy` for exactly 2 cycles. It issues one RAM read at address number-1 in the first busy cycle and no RAM write.
- R5: On a read, each group whose select bit is set is copied into the buffer: bit 0 selects data bits 31:0, bit 1 data bits 63:32, bit 6 the mask word, bit 5 the arbitration word and bit 4 the control word. Unselected buffer groups keep their value. The buffer changes on the same edge at which `busy` falls.
- R6: On a read with mask bit 2 (clear new-data, object bit 139) or bit 3 (clear interrupt-pending, object bit 137) set, `busy` lasts 3 cycles. In the last busy cycle, one RAM write puts back the object with only the requested flags cleared.
- R7: When a read clears flags, the control word placed in the buffer carries the flag values from before the clear.
- R8: A write (mask bit 7 set) lasts 3 cycles and ends with one RAM write. Selected groups come from the buffer and unselected groups from RAM. Bits 2 and 3 clear nothing, and the buffer is unchanged.
- R9: While `busy` is high, requests, mask writes and buffer writes are ignored.
- R10: While idle, a buffer write loads each group whose `buf_wr_grp` bit is set from `buf_wr_data`. The group order is bit 0 data 31:0, bit 1 data 63:32, bit 2 mask word (94:64), bit 3 arbitration word (126:95) and bit 4 control word (139:127).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mask_wr | input | 1 | Command mask write strobe |
| mask_wdata | input | 32 | Command mask write value |
| mask_rdata | output | 32 | Command mask readback |
| req_wr | input | 1 | Command request strobe |
| req_num | input | NUM_W (6) | Object number, 1-based |
| busy | output | 1 | Transfer in progress |
| buf_wr_en | input | 1 | Buffer write strobe |
| buf_wr_grp | input | 5 | Per-group buffer write enables |
| buf_wr_data | input | 140 | Buffer write value, object layout |
| buf_q | output | 140 | Buffer contents, object layout |
| ram_rd_en | output | 1 | RAM read request |
| ram_wr_en | output | 1 | RAM write request |
| ram_addr | output | AW (5) | RAM entry index |
| ram_wdata | output | 140 | RAM write data |
| ram_rdata | input | 140 | RAM read data, one cycle after `ram_rd_en` |

## Verification
A wrong sequencer state shows up in the first busy cycle, as a missing or extra RAM read, or as a `busy` pulse one cycle too long or too short. A wrong group select or flag merge shows up in `buf_q` on the edge where `busy` falls, or in the RAM entry right after the write-back. The reference model predicts `busy`, both RAM strobes, the mask readback and the buffer on every clock, so a divergence is caught in the cycle it first appears.

// File: rtl/msgobj_pkg.sv
// Shared layout of a message object and of the command mask.
// Assumes a fixed object format: control, arbitration, mask, two data halves.
package msgobj_pkg;

    localparam int CTRL_W  = 13;
    localparam int ARB_W   = 32;
    localparam int MSK_W   = 31;
    localparam int HALF_W  = 32;
    localparam int OBJ_W   = CTRL_W + ARB_W + MSK_W + 2 * HALF_W;
    localparam int NGRP    = 5;
    localparam int CMD_W   = 8;

    // Command mask bit positions
    localparam int MB_DIR     = 7;
    localparam int MB_CLR_INT = 3;
    localparam int MB_CLR_NEW = 2;

    // Flag positions inside the control word
    localparam int CB_NEWDAT = 12;
    localparam int CB_INTPND = 10;

    // Group index: 0 data low, 1 data high, 2 mask, 3 arbitration, 4 control
    function automatic int grp_lo(input int g);
        case (g)
            0:       return 0;
            1:       return HALF_W;
            2:       return 2 * HALF_W;
            3:       return 2 * HALF_W + MSK_W;
            default: return 2 * HALF_W + MSK_W + ARB_W;
        endcase
    endfunction

    function automatic int grp_w(input int g);
        case (g)
            0, 1:    return HALF_W;
            2:       return MSK_W;
            3:       return ARB_W;
            default: return CTRL_W;
        endcase
    endfunction

    // Command mask bit that selects group g
    function automatic int grp_sel(input int g);
        case (g)
            0:       return 0;
            1:       return 1;
            2:       return 6;
            3:       return 5;
            default: return 4;
        endcase
    endfunction

    localparam int NEWDAT_BIT = grp_lo(4) + CB_NEWDAT;
    localparam int INTPND_BIT = grp_lo(4) + CB_INTPND;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RD   = 2'd1,
        ST_CAP  = 2'd2,
        ST_WB   = 2'd3
    } xfer_state_e;

endpackage

// File: rtl/msgobj_cmd_regs.sv
// Command mask register and request decode.
// Assumes the sequencer reports idle; all writes are dropped while busy.
module msgobj_cmd_regs
    import msgobj_pkg::*;
#(
    parameter int NUM_OBJ = 32,
    parameter int NUM_W   = $clog2(NUM_OBJ + 1),
    parameter int AW      = $clog2(NUM_OBJ)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 idle,
    input  logic                 mask_wr,
    input  logic [31:0]          mask_wdata,
    input  logic                 req_wr,
    input  logic [NUM_W-1:0]     req_num,
    output logic [CMD_W-1:0]     mask_q,
    output logic                 start,
    output logic [AW-1:0]        start_addr
);
    localparam logic [NUM_W-1:0] MAX_NUM = NUM_W'(NUM_OBJ);
    localparam logic [NUM_W-1:0] ONE     = NUM_W'(1);

    // Hold the defined command mask bits; accept writes only when idle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= '0;
        end else if (mask_wr && idle) begin
            mask_q <= mask_wdata[CMD_W-1:0];
        end
    end

    // Decode a request: accept only when idle and the number is in range
    always_comb begin
        start      = req_wr && idle && (req_num != '0) && (req_num <= MAX_NUM);
        start_addr = AW'(req_num - ONE);
    end
endmodule

// File: rtl/msgobj_seq.sv
// Transfer sequencer: RAM read, capture, optional write-back.
// Assumes a synchronous RAM that returns data one cycle after the read strobe.
module msgobj_seq
    import msgobj_pkg::*;
#(
    parameter int AW = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [AW-1:0]     start_addr,
    input  logic              need_wb,
    input  logic [OBJ_W-1:0]  ram_rdata,
    output logic              idle,
    output logic              ram_rd_en,
    output logic              ram_wr_en,
    output logic [AW-1:0]     ram_addr,
    output logic              done,
    output logic [OBJ_W-1:0]  obj_src
);
    xfer_state_e          state;
    logic [AW-1:0]        addr_q;
    logic [OBJ_W-1:0]     hold_q;

    // Advance the transfer state and keep the captured object
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            addr_q <= '0;
            hold_q <= '0;
        end else begin
            case (state)
                ST_IDLE: if (start) begin
                    addr_q <= start_addr;
                    state  <= ST_RD;
                end
                ST_RD:   state <= ST_CAP;
                ST_CAP: begin
                    hold_q <= ram_rdata;
                    state  <= need_wb ? ST_WB : ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Drive RAM strobes, completion and the current object source
    always_comb begin
        idle      = (state == ST_IDLE);
        ram_rd_en = (state == ST_RD);
        ram_wr_en = (state == ST_WB);
        ram_addr  = addr_q;
        done      = ((state == ST_CAP) && !need_wb) || (state == ST_WB);
        obj_src   = (state == ST_CAP) ? ram_rdata : hold_q;
    end
endmodule

// File: rtl/msgobj_merge.sv
// Per-group merge between RAM object and buffer, in both directions.
// Assumes the command mask is stable for the whole transfer.
module msgobj_merge
    import msgobj_pkg::*;
(
    input  logic [CMD_W-1:0]  mask,
    input  logic [OBJ_W-1:0]  obj,
    input  logic [OBJ_W-1:0]  bufv,
    output logic [OBJ_W-1:0]  rd_buf,
    output logic [OBJ_W-1:0]  wb_obj
);
    logic              dir_wr;
    logic [OBJ_W-1:0]  wb_raw;

    // Direction from the command mask
    always_comb dir_wr = mask[MB_DIR];

    for (genvar g = 0; g < NGRP; g++) begin : g_grp
        localparam int LO  = grp_lo(g);
        localparam int W   = grp_w(g);
        localparam int SEL = grp_sel(g);
        // Pick each group's source for buffer and RAM images
        always_comb begin
            rd_buf[LO +: W] = mask[SEL] ? obj[LO +: W] : bufv[LO +: W];
            wb_raw[LO +: W] = (dir_wr && mask[SEL]) ? bufv[LO +: W] : obj[LO +: W];
        end
    end

    // Apply flag clears on reads only
    always_comb begin
        wb_obj = wb_raw;
        if (!dir_wr) begin
            if (mask[MB_CLR_NEW]) wb_obj[NEWDAT_BIT] = 1'b0;
            if (mask[MB_CLR_INT]) wb_obj[INTPND_BIT] = 1'b0;
        end
    end
endmodule

// File: rtl/msgobj_ifbuf.sv
// Interface buffer register set, loaded per group by host or by a transfer.
// Assumes host loads and transfer loads never coincide (host gated by idle).
module msgobj_ifbuf
    import msgobj_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_wr,
    input  logic [NGRP-1:0]   host_grp,
    input  logic [OBJ_W-1:0]  host_data,
    input  logic              xfer_ld,
    input  logic [OBJ_W-1:0]  xfer_data,
    output logic [OBJ_W-1:0]  buf_q
);
    for (genvar g = 0; g < NGRP; g++) begin : g_grp
        localparam int LO = grp_lo(g);
        localparam int W  = grp_w(g);
        // Update one group from the host port or from a read transfer
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                buf_q[LO +: W] <= '0;
            end else if (host_wr && host_grp[g]) begin
                buf_q[LO +: W] <= host_data[LO +: W];
            end else if (xfer_ld) begin
                buf_q[LO +: W] <= xfer_data[LO +: W];
            end
        end
    end
endmodule

// File: rtl/msgobj_xfer.sv
// Top: message object transfer controller.
// Assumes one external synchronous RAM of NUM_OBJ objects, 1-cycle read latency.
module msgobj_xfer
    import msgobj_pkg::*;
#(
    parameter int NUM_OBJ = 32,
    parameter int NUM_W   = $clog2(NUM_OBJ + 1),
    parameter int AW      = $clog2(NUM_OBJ)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mask_wr,
    input  logic [31:0]       mask_wdata,
    output logic [31:0]       mask_rdata,
    input  logic              req_wr,
    input  logic [NUM_W-1:0]  req_num,
    output logic              busy,
    input  logic              buf_wr_en,
    input  logic [NGRP-1:0]   buf_wr_grp,
    input  logic [OBJ_W-1:0]  buf_wr_data,
    output logic [OBJ_W-1:0]  buf_q,
    output logic              ram_rd_en,
    output logic              ram_wr_en,
    output logic [AW-1:0]     ram_addr,
    output logic [OBJ_W-1:0]  ram_wdata,
    input  logic [OBJ_W-1:0]  ram_rdata
);
    logic              idle;
    logic              start;
    logic [AW-1:0]     start_addr;
    logic [CMD_W-1:0]  mask_q;
    logic              need_wb;
    logic              done;
    logic [OBJ_W-1:0]  obj_src;
    logic [OBJ_W-1:0]  rd_buf;

    msgobj_cmd_regs #(.NUM_OBJ(NUM_OBJ), .NUM_W(NUM_W), .AW(AW)) u_cmd (
        .clk(clk), .rst_n(rst_n), .idle(idle),
        .mask_wr(mask_wr), .mask_wdata(mask_wdata),
        .req_wr(req_wr), .req_num(req_num),
        .mask_q(mask_q), .start(start), .start_addr(start_addr)
    );

    // Write-back is needed for writes and for flag-clearing reads
    always_comb begin
        need_wb    = mask_q[MB_DIR] | mask_q[MB_CLR_NEW] | mask_q[MB_CLR_INT];
        mask_rdata = {{(32 - CMD_W){1'b0}}, mask_q};
        busy       = !idle;
    end

    msgobj_seq #(.AW(AW)) u_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr),
        .need_wb(need_wb), .ram_rdata(ram_rdata), .idle(idle),
        .ram_rd_en(ram_rd_en), .ram_wr_en(ram_wr_en), .ram_addr(ram_addr),
        .done(done), .obj_src(obj_src)
    );

    msgobj_merge u_merge (
        .mask(mask_q), .obj(obj_src), .bufv(buf_q),
        .rd_buf(rd_buf), .wb_obj(ram_wdata)
    );

    msgobj_ifbuf u_buf (
        .clk(clk), .rst_n(rst_n),
        .host_wr(buf_wr_en && idle), .host_grp(buf_wr_grp), .host_data(buf_wr_data),
        .xfer_ld(done && !mask_q[MB_DIR]), .xfer_data(rd_buf),
        .buf_q(buf_q)
    );
endmodule

// File: rtl/msgobj_xfer_chk.sv
// Port-level protocol checks for msgobj_xfer, attached by bind.
module msgobj_xfer_chk #(
    parameter int NUM_OBJ = 32,
    parameter int NUM_W   = 6,
    parameter int AW      = 5,
    parameter int OBJ_W   = 140
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic              req_wr,
    input logic [NUM_W-1:0]  req_num,
    input logic [31:0]       mask_rdata,
    input logic [OBJ_W-1:0]  buf_q,
    input logic              ram_rd_en,
    input logic              ram_wr_en,
    input logic [AW-1:0]     ram_addr
);
    localparam logic [NUM_W-1:0] MAX_NUM = NUM_W'(NUM_OBJ);

    // R3: number zero never starts a transfer
    p_zero_ignored_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && req_wr && req_num == '0) |=> !busy);

    // R3: in-range request while idle starts with a RAM read
    p_start_reads_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && req_wr && req_num != '0 && req_num <= MAX_NUM) |=> (busy && ram_rd_en));

    // R4: a read strobe is followed by a busy cycle without another read
    p_single_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ram_rd_en |=> (busy && !ram_rd_en));

    // R4: no RAM write outside a transfer
    p_no_idle_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !ram_wr_en);

    // R6: write-back ends the transfer
    p_wb_last_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ram_wr_en |=> !busy);

    // R9: buffer and mask stay fixed between busy cycles
    p_buf_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(buf_q));
    p_mask_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(mask_rdata));

    // R8: the write-back targets the address that was read
    p_wb_addr_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ram_rd_en |=> $stable(ram_addr));
endmodule

bind msgobj_xfer msgobj_xfer_chk #(
    .NUM_OBJ(NUM_OBJ), .NUM_W(NUM_W), .AW(AW), .OBJ_W(msgobj_pkg::OBJ_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .busy(busy), .req_wr(req_wr), .req_num(req_num),
    .mask_rdata(mask_rdata), .buf_q(buf_q), .ram_rd_en(ram_rd_en),
    .ram_wr_en(ram_wr_en), .ram_addr(ram_addr)
);

// File: tb/msgobj_xfer_tb.sv
module msgobj_xfer_tb;
    localparam int N  = 32;
    localparam int NW = 6;
    localparam int AW = 5;
    localparam int OW = 140;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic mask_wr = 1'b0;
    logic [31:0] mask_wdata = '0;
    logic [31:0] mask_rdata;
    logic req_wr = 1'b0;
    logic [NW-1:0] req_num = '0;
    logic busy;
    logic buf_wr_en = 1'b0;
    logic [4:0] buf_wr_grp = '0;
    logic [OW-1:0] buf_wr_data = '0;
    logic [OW-1:0] buf_q;
    logic ram_rd_en, ram_wr_en;
    logic [AW-1:0] ram_addr;
    logic [OW-1:0] ram_wdata;
    logic [OW-1:0] ram_rdata = '0;

    always #4 clk = ~clk;

    msgobj_xfer #(.NUM_OBJ(N)) u_dut (
        .clk(clk), .rst_n(rst_n), .mask_wr(mask_wr), .mask_wdata(mask_wdata),
        .mask_rdata(mask_rdata), .req_wr(req_wr), .req_num(req_num), .busy(busy),
        .buf_wr_en(buf_wr_en), .buf_wr_grp(buf_wr_grp), .buf_wr_data(buf_wr_data),
        .buf_q(buf_q), .ram_rd_en(ram_rd_en), .ram_wr_en(ram_wr_en),
        .ram_addr(ram_addr), .ram_wdata(ram_wdata), .ram_rdata(ram_rdata)
    );

    // Bench RAM (real) and reference copy
    logic [OW-1:0] mem [N];
    logic [OW-1:0] mem_ref [N];

    always @(posedge clk) begin
        if (ram_wr_en) mem[ram_addr] <= ram_wdata;
        if (ram_rd_en) ram_rdata <= mem[ram_addr];
    end

    int n_chk = 0;
    int n_err = 0;
    string cur_tag = "R1";

    task automatic chk(input bit ok, input string tag, input logic [159:0] act, input logic [159:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Group field ranges, from the requirements
    function automatic logic [OW-1:0] grp_bits(input int g);
        logic [OW-1:0] m;
        m = '0;
        case (g)
            0: m[31:0]    = '1;
            1: m[63:32]   = '1;
            2: m[94:64]   = '1;
            3: m[126:95]  = '1;
            default: m[139:127] = '1;
        endcase
        return m;
    endfunction

    // Group of command mask bit: 0,1,6,5,4 -> groups 0..4
    function automatic logic [OW-1:0] sel_bits(input logic [7:0] m);
        logic [OW-1:0] r;
        r = '0;
        if (m[0]) r |= grp_bits(0);
        if (m[1]) r |= grp_bits(1);
        if (m[6]) r |= grp_bits(2);
        if (m[5]) r |= grp_bits(3);
        if (m[4]) r |= grp_bits(4);
        return r;
    endfunction

    function automatic logic [OW-1:0] pattern(input int i);
        logic [159:0] t;
        logic [31:0] w;
        w = 32'hA5C3_0F1E ^ (32'(i) * 32'h0101_0101);
        t = {w, ~w, w ^ 32'h5A5A_5A5A, w + 32'd7, ~w ^ 32'h1234_5678};
        t[139] = 1'b1;
        t[137] = (i % 2 == 0);
        return t[OW-1:0];
    endfunction

    // Reference model state
    int            m_cnt = 0;
    int            m_dur = 0;
    bit            m_wb = 0;
    bit            m_fin = 0;
    int            m_addr = 0;
    logic [7:0]    m_mask = '0;
    logic [OW-1:0] m_buf = '0;
    logic [OW-1:0] p_buf, p_obj;

    always @(posedge clk) begin
        m_fin = 0;
        if (!rst_n) begin
            m_cnt = 0; m_mask = '0; m_buf = '0;
        end else if (m_cnt > 0) begin
            m_cnt--;
            if (m_cnt == 0) begin
                m_buf = p_buf;
                mem_ref[m_addr] = p_obj;
                m_fin = 1;
            end
        end else begin
            logic [OW-1:0] o, s;
            if (mask_wr) m_mask = mask_wdata[7:0];
            if (buf_wr_en)
                for (int g = 0; g < 5; g++)
                    if (buf_wr_grp[g]) m_buf = (m_buf & ~grp_bits(g)) | (buf_wr_data & grp_bits(g));
            if (req_wr && req_num >= 1 && req_num <= N) begin
                m_addr = int'(req_num) - 1;
                o = mem_ref[m_addr];
                s = sel_bits(m_mask);
                m_wb = m_mask[7] || m_mask[2] || m_mask[3];
                m_dur = m_wb ? 3 : 2;
                m_cnt = m_dur;
                if (!m_mask[7]) begin
                    p_buf = (m_buf & ~s) | (o & s);
                    p_obj = o;
                    if (m_mask[2]) p_obj[139] = 1'b0;
                    if (m_mask[3]) p_obj[137] = 1'b0;
                end else begin
                    p_buf = m_buf;
                    p_obj = (o & ~s) | (m_buf & s);
                end
            end
        end
    end

    // Compare on every clock, away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            chk(busy == (m_cnt > 0), cur_tag, 160'(busy), 160'(m_cnt > 0));
            chk(buf_q == m_buf, cur_tag, 160'(buf_q), 160'(m_buf));
            chk(mask_rdata == {24'b0, m_mask}, cur_tag, 160'(mask_rdata), 160'(m_mask));
            chk(ram_rd_en == (m_cnt > 0 && m_cnt == m_dur), cur_tag, 160'(ram_rd_en), 160'(m_cnt == m_dur));
            chk(ram_wr_en == (m_cnt == 1 && m_wb), cur_tag, 160'(ram_wr_en), 160'(m_cnt == 1 && m_wb));
            if (ram_rd_en || ram_wr_en)
                chk(int'(ram_addr) == m_addr, cur_tag, 160'(ram_addr), 160'(m_addr));
            if (m_fin)
                chk(mem[m_addr] == mem_ref[m_addr], cur_tag, 160'(mem[m_addr]), 160'(mem_ref[m_addr]));
        end
    end

    task automatic set_mask(input logic [31:0] v);
        mask_wr = 1'b1; mask_wdata = v;
        @(negedge clk);
        mask_wr = 1'b0;
    endtask

    task automatic load_buf(input logic [4:0] g, input logic [OW-1:0] d);
        buf_wr_en = 1'b1; buf_wr_grp = g; buf_wr_data = d;
        @(negedge clk);
        buf_wr_en = 1'b0;
    endtask

    task automatic request(input int n);
        req_wr = 1'b1; req_num = NW'(n);
        @(negedge clk);
        req_wr = 1'b0;
        for (int k = 0; k < 10 && busy; k++) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic summary;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    endtask

    initial begin
        #(8 * 20000);
        n_chk++; n_err++;
        $display("FAIL watchdog: actual hung expected done");
        summary();
        $finish;
    end

    initial begin
        for (int i = 0; i < N; i++) begin
            mem[i] = pattern(i);
            mem_ref[i] = pattern(i);
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        chk(!busy && !ram_rd_en && !ram_wr_en, "R1", 160'({busy, ram_rd_en, ram_wr_en}), 160'(0));
        chk(buf_q == '0 && mask_rdata == '0, "R1", 160'(buf_q), 160'(0));
        @(negedge clk);

        // R2: reserved bits read zero
        cur_tag = "R2";
        set_mask(32'hFFFF_FF00 | 32'h31);
        chk(mask_rdata == 32'h31, "R2", 160'(mask_rdata), 160'(32'h31));

        // R10: host buffer loads per group
        cur_tag = "R10";
        load_buf(5'b10101, {OW{1'b1}});
        chk(buf_q == (grp_bits(0) | grp_bits(2) | grp_bits(4)), "R10", 160'(buf_q),
            160'(grp_bits(0) | grp_bits(2) | grp_bits(4)));
        load_buf(5'b00010, '0);

        // R4, R5: read all groups, no clear
        cur_tag = "R4";
        set_mask(32'h73);
        request(5);
        chk(buf_q == mem_ref[4], "R5", 160'(buf_q), 160'(mem_ref[4]));

        // R5: read arbitration only keeps other groups
        cur_tag = "R5";
        set_mask(32'h20);
        request(10);
        request(N);

        // R6, R7: read control with both clears
        cur_tag = "R6";
        set_mask(32'h1C);
        request(3);
        chk(buf_q[139] == 1'b1 && buf_q[137] == 1'b1, "R7", 160'(buf_q[139:127]), 160'(pattern(2)));
        chk(mem[2][139] == 1'b0 && mem[2][137] == 1'b0, "R6", 160'(mem[2]), 160'(mem_ref[2]));

        // R6: clear new-data only, no groups
        set_mask(32'h04);
        request(8);
        chk(mem[7][137] == pattern(7)[137] && mem[7][139] == 1'b0, "R6", 160'(mem[7]), 160'(mem_ref[7]));

        // R8: write mask and data high with clears ignored
        cur_tag = "R8";
        load_buf(5'b11111, pattern(20) ^ {OW{1'b1}});
        set_mask(32'hCE);
        request(12);
        chk(mem[11][94:32] == buf_q[94:32], "R8", 160'(mem[11]), 160'(mem_ref[11]));
        set_mask(32'h73);
        request(12);

        // R3: out-of-range numbers ignored
        cur_tag = "R3";
        request(0);
        request(N + 1);
        chk(!busy, "R3", 160'(busy), 160'(0));

        // R9: host actions during busy are dropped
        cur_tag = "R9";
        set_mask(32'h10);
        req_wr = 1'b1; req_num = NW'(6);
        @(negedge clk);
        req_num = NW'(9);
        mask_wr = 1'b1; mask_wdata = 32'h80;
        buf_wr_en = 1'b1; buf_wr_grp = 5'b11111; buf_wr_data = '0;
        @(negedge clk);
        req_wr = 1'b0; mask_wr = 1'b0; buf_wr_en = 1'b0;
        repeat (4) @(negedge clk);
        chk(mask_rdata == 32'h10, "R9", 160'(mask_rdata), 160'(32'h10));
        chk(buf_q[139:127] == pattern(5)[139:127], "R9", 160'(buf_q), 160'(pattern(5)));

        repeat (3) @(negedge clk);
        summary();
        $finish;
    end
endmodule